// File: doc/BRIEF.md
# Raster-Op Block Transfer Engine

This engine fills a rectangle of pixels in a word-addressed frame memory. Every destination pixel is replaced by a three-operand raster operation over a source pixel, a pattern pixel and the old destination pixel. The source pixel can come from one of three places:

- a color rectangle in memory;
- a monochrome bitmap whose bits are expanded to foreground or background color;
- a solid foreground fill.

The pattern is a fixed 8x8 monochrome tile that is expanded with the same two colors. Each memory word holds one pixel, and each rectangle row begins one pitch after the previous row. A transparency mode can suppress individual writes. When a color source overlaps its destination, the engine walks the rectangle backwards so that no source pixel is overwritten before it is read.

The command inputs must stay stable from the start pulse until the done pulse. The memory side is a single request port. A read's data appears on `mem_rdata` in the cycle after the request, and a write completes at the requesting edge.

The control is one state machine with these states and transitions:

- **IDLE**: waits for start, then goes to **SETUP**.
- **SETUP**: latches direction and start corners. It goes to **DONE** on an empty rectangle, to **RD_DST** for a solid source, and to **RD_SRC** otherwise.
- **RD_SRC**: issues the source read, then goes to **RD_DST**.
- **RD_DST**: captures the source word and issues the destination read, then goes to **WRITE**.
- **WRITE**: computes the pixel, writes it if allowed, and steps the position. After the last pixel it goes to **DONE**. Otherwise it returns to **RD_SRC**, or to **RD_DST** for a solid source.
- **DONE**: pulses done, then goes to **IDLE**.

Top module: `blt_engine`

## Requirements
- R1: Bit i of each result equals bit number {P[i],S[i],D[i]} of the 8-bit ROP code, with P as the most significant index bit. Code CC hex copies the source, F0 hex copies the pattern, 00 hex gives zero and FF hex gives all ones within the pixel depth.
- R2: The pattern pixel at rectangle-relative position (x,y) comes from pattern bit 8*(y mod 8)+(x mod 8). A 1 in that bit gives the foreground color and a 0 gives the background color.
- R3: Depth code 0 selects 8 bits per pixel, code 1 selects 16, and codes 2 and 3 select 32. Operands are taken from the low bits of a word, and written words have every bit above the depth cleared.
- R4: Source mode 0 reads the color word at source row base + x. Mode 1 reads the word at source row base + x/32 and takes bit x mod 32, where 1 gives foreground and 0 gives background. Modes 2 and 3 use the foreground color and make no source reads.
- R5: Transparency mode 0 and mode 3 always write. Mode 1 writes only where the source color differs from the key. Mode 2 writes only where the old destination color equals the key. All comparisons use the pixel depth. A skipped pixel keeps its full old word.
- R6: Pixel (x,y) lies at base + y*pitch + x, and no word outside the destination rectangle changes. When the source is a color region, the destination address is above the source address, and the destination address is at or below the last source word, the walk runs bottom-to-top and right-to-left. In every other case it runs top-to-bottom and left-to-right. The result is always a copy of the source as it was before the transfer.
- R7: A start pulse while idle raises busy in the next cycle. Busy stays high until the cycle of the single-cycle done pulse, which follows the last destination write, and falls in the cycle after done. A start pulse while busy is ignored.
- R8: A width or height of zero produces a done pulse two cycles after start, with no memory request.
- R9: No memory request is issued while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse |
| src_addr | input | AW | Word address of source pixel (0,0) |
| dst_addr | input | AW | Word address of destination pixel (0,0) |
| src_pitch | input | AW | Words between source rows |
| dst_pitch | input | AW | Words between destination rows |
| width | input | CW | Pixels per row |
| height | input | CW | Rows |
| depth | input | 2 | Pixel depth code |
| rop | input | 8 | Raster-op code |
| src_mode | input | 2 | Source kind |
| pattern | input | 64 | 8x8 monochrome tile |
| fg_color | input | DW | Foreground color |
| bg_color | input | DW | Background color |
| trans_mode | input | 2 | Transparency mode |
| key_color | input | DW | Transparency key |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Completion pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, one cycle after a read request |

## Verification
A table of transfers runs over one 10x10 rectangle and varies the ROP code, the depth, the source kind and the transparency mode. Pure source, pure pattern, mixed and constant codes separate the bit indexing and operand order of R1. The 10-pixel size wraps the 8x8 tile, and the three depths reveal masking faults. Keys are placed on real source and destination pixels, which separates the two transparency modes from each other and from opaque writes. Directed transfers then copy rectangles shifted one word right, one row down and one word left, so that a wrong walk direction corrupts the copy. They also exercise empty rectangles and a repeated start while busy.

// File: rtl/blt_pkg.sv
package blt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_RD_SRC,
        ST_RD_DST,
        ST_WRITE,
        ST_DONE
    } blt_state_e;

    localparam logic [1:0] SRC_COLOR = 2'd0;
    localparam logic [1:0] SRC_MONO  = 2'd1;

    localparam logic [1:0] TR_SRC_KEY = 2'd1;
    localparam logic [1:0] TR_DST_KEY = 2'd2;

endpackage

// File: rtl/blt_rop_unit.sv
module blt_rop_unit #(
    parameter int DW = 32
) (
    input  logic [7:0]    rop,
    input  logic [DW-1:0] s_pix,
    input  logic [DW-1:0] p_pix,
    input  logic [DW-1:0] d_pix,
    output logic [DW-1:0] r_pix
);
    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign r_pix[i] = rop[{p_pix[i], s_pix[i], d_pix[i]}];
    end
endmodule

// File: rtl/blt_color_gen.sv
module blt_color_gen #(
    parameter int DW = 32,
    localparam int BW = $clog2(DW)
) (
    input  logic [1:0]    src_mode,
    input  logic [DW-1:0] src_word,
    input  logic [BW-1:0] bit_sel,
    input  logic [5:0]    pat_idx,
    input  logic [63:0]   pattern,
    input  logic [DW-1:0] fg_color,
    input  logic [DW-1:0] bg_color,
    input  logic [DW-1:0] mask,
    output logic [DW-1:0] src_c,
    output logic [DW-1:0] pat_c
);
    import blt_pkg::*;

    always_comb begin
        unique case (src_mode)
            SRC_COLOR: src_c = src_word & mask;
            SRC_MONO:  src_c = (src_word[bit_sel] ? fg_color : bg_color) & mask;
            default:   src_c = fg_color & mask;
        endcase
        pat_c = (pattern[pat_idx] ? fg_color : bg_color) & mask;
    end
endmodule

// File: rtl/blt_dir_sel.sv
module blt_dir_sel #(
    parameter int AW = 16,
    parameter int CW = 12
) (
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic [AW-1:0] src_pitch,
    input  logic [AW-1:0] dst_pitch,
    input  logic [CW-1:0] width,
    input  logic [CW-1:0] height,
    input  logic          color_src,
    output logic          reverse,
    output logic [AW-1:0] src_last_row,
    output logic [AW-1:0] dst_last_row
);
    logic [AW-1:0] hm1;
    logic [AW-1:0] wm1;
    logic [AW-1:0] src_end;

    always_comb begin
        hm1          = {{(AW-CW){1'b0}}, height - CW'(1)};
        wm1          = {{(AW-CW){1'b0}}, width - CW'(1)};
        src_last_row = src_addr + hm1 * src_pitch;
        dst_last_row = dst_addr + hm1 * dst_pitch;
        src_end      = src_last_row + wm1;
        reverse      = color_src && (dst_addr > src_addr) && (dst_addr <= src_end);
    end
endmodule

// File: rtl/blt_engine.sv
module blt_engine #(
    parameter int AW = 16,
    parameter int CW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic [AW-1:0] src_pitch,
    input  logic [AW-1:0] dst_pitch,
    input  logic [CW-1:0] width,
    input  logic [CW-1:0] height,
    input  logic [1:0]    depth,
    input  logic [7:0]    rop,
    input  logic [1:0]    src_mode,
    input  logic [63:0]   pattern,
    input  logic [DW-1:0] fg_color,
    input  logic [DW-1:0] bg_color,
    input  logic [1:0]    trans_mode,
    input  logic [DW-1:0] key_color,
    output logic          busy,
    output logic          done,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    import blt_pkg::*;

    localparam int BW = $clog2(DW);

    blt_state_e    state_q, state_d;
    logic [CW-1:0] xx_q, yy_q;
    logic [AW-1:0] src_row_q, dst_row_q;
    logic [DW-1:0] src_q;
    logic          rev_q;

    logic          solid, empty, rev_w;
    logic [AW-1:0] src_last_row, dst_last_row;
    logic [DW-1:0] mask, src_c, pat_c, dst_m, rop_out, key_m;
    logic          row_end, last_row, wr_ok;
    logic [AW-1:0] xx_ext, src_rd_addr;

    assign solid  = src_mode[1];
    assign empty  = (width == '0) || (height == '0);
    assign xx_ext = {{(AW-CW){1'b0}}, xx_q};

    always_comb begin
        unique case (depth)
            2'd0:    mask = {{(DW-8){1'b0}}, 8'hFF};
            2'd1:    mask = {{(DW-16){1'b0}}, 16'hFFFF};
            default: mask = '1;
        endcase
    end

    blt_dir_sel #(.AW(AW), .CW(CW)) i_dir (
        .src_addr     (src_addr),
        .dst_addr     (dst_addr),
        .src_pitch    (src_pitch),
        .dst_pitch    (dst_pitch),
        .width        (width),
        .height       (height),
        .color_src    (src_mode == SRC_COLOR),
        .reverse      (rev_w),
        .src_last_row (src_last_row),
        .dst_last_row (dst_last_row)
    );

    blt_color_gen #(.DW(DW)) i_color (
        .src_mode (src_mode),
        .src_word (src_q),
        .bit_sel  (xx_q[BW-1:0]),
        .pat_idx  ({yy_q[2:0], xx_q[2:0]}),
        .pattern  (pattern),
        .fg_color (fg_color),
        .bg_color (bg_color),
        .mask     (mask),
        .src_c    (src_c),
        .pat_c    (pat_c)
    );

    assign dst_m = mem_rdata & mask;
    assign key_m = key_color & mask;

    blt_rop_unit #(.DW(DW)) i_rop (
        .rop   (rop),
        .s_pix (src_c),
        .p_pix (pat_c),
        .d_pix (dst_m),
        .r_pix (rop_out)
    );

    always_comb begin
        unique case (trans_mode)
            TR_SRC_KEY: wr_ok = (src_c != key_m);
            TR_DST_KEY: wr_ok = (dst_m == key_m);
            default:    wr_ok = 1'b1;
        endcase
    end

    assign row_end  = rev_q ? (xx_q == '0) : (xx_q == width - CW'(1));
    assign last_row = rev_q ? (yy_q == '0) : (yy_q == height - CW'(1));
    assign src_rd_addr = (src_mode == SRC_MONO) ? src_row_q + (xx_ext >> BW)
                                                : src_row_q + xx_ext;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SETUP;
            ST_SETUP:  state_d = empty ? ST_DONE : (solid ? ST_RD_DST : ST_RD_SRC);
            ST_RD_SRC: state_d = ST_RD_DST;
            ST_RD_DST: state_d = ST_WRITE;
            ST_WRITE:  state_d = (row_end && last_row) ? ST_DONE
                               : (solid ? ST_RD_DST : ST_RD_SRC);
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xx_q      <= '0;
            yy_q      <= '0;
            src_row_q <= '0;
            dst_row_q <= '0;
            src_q     <= '0;
            rev_q     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_SETUP: begin
                    rev_q     <= rev_w;
                    xx_q      <= rev_w ? width - CW'(1) : '0;
                    yy_q      <= rev_w ? height - CW'(1) : '0;
                    src_row_q <= rev_w ? src_last_row : src_addr;
                    dst_row_q <= rev_w ? dst_last_row : dst_addr;
                end
                ST_RD_DST: if (!solid) src_q <= mem_rdata;
                ST_WRITE: begin
                    if (row_end) begin
                        xx_q      <= rev_q ? width - CW'(1) : '0;
                        yy_q      <= rev_q ? yy_q - CW'(1) : yy_q + CW'(1);
                        src_row_q <= rev_q ? src_row_q - src_pitch : src_row_q + src_pitch;
                        dst_row_q <= rev_q ? dst_row_q - dst_pitch : dst_row_q + dst_pitch;
                    end else begin
                        xx_q <= rev_q ? xx_q - CW'(1) : xx_q + CW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = 1'b1;
        done      = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_SETUP:  ;
            ST_RD_SRC: begin
                mem_req  = 1'b1;
                mem_addr = src_rd_addr;
            end
            ST_RD_DST: begin
                mem_req  = 1'b1;
                mem_addr = dst_row_q + xx_ext;
            end
            ST_WRITE: begin
                mem_req   = wr_ok;
                mem_we    = wr_ok;
                mem_addr  = dst_row_q + xx_ext;
                mem_wdata = rop_out & mask;
            end
            ST_DONE:   done = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    // R9: the memory port is quiet whenever the engine is idle
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R7: an accepted start raises busy in the next cycle
    a_r7_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R7: busy drops in the cycle after the done pulse
    a_r7_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done));

    // R8: an empty rectangle finishes without touching memory
    a_r8_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && ((width == '0) || (height == '0)))
        |=> (!mem_req ##1 (done && !mem_req)));

    // R3: 8-bit writes clear the upper bits of the word
    a_r3_depth8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && depth == 2'd0) |-> (mem_wdata[DW-1:8] == '0));

endmodule

// File: tb/test_blt_engine.sv
`timescale 1ns/1ps
module test_blt_engine;
    localparam int AW = 16, CW = 12, DW = 32, MW = 1024;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [AW-1:0] src_addr, dst_addr, src_pitch, dst_pitch;
    logic [CW-1:0] width, height;
    logic [1:0] depth, src_mode, trans_mode;
    logic [7:0] rop;
    logic [63:0] pattern;
    logic [DW-1:0] fg_color, bg_color, key_color;
    logic busy, done, mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    logic [DW-1:0] mem  [MW];
    logic [DW-1:0] snap [MW];
    logic [DW-1:0] expm [MW];

    int n_tests = 0, n_fail = 0, req_cnt = 0, done_cnt = 0;

    always #4 clk = ~clk;

    blt_engine #(.AW(AW), .CW(CW), .DW(DW)) i_blt_engine (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_addr(src_addr), .dst_addr(dst_addr),
        .src_pitch(src_pitch), .dst_pitch(dst_pitch),
        .width(width), .height(height), .depth(depth), .rop(rop),
        .src_mode(src_mode), .pattern(pattern),
        .fg_color(fg_color), .bg_color(bg_color),
        .trans_mode(trans_mode), .key_color(key_color),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
            mem_rdata <= mem[mem_addr[9:0]];
        end
        if (mem_req) req_cnt <= req_cnt + 1;
        if (done)    done_cnt <= done_cnt + 1;
    end

    // table: {rop, src_mode, depth, trans_mode}
    localparam logic [13:0] VEC [10] = '{
        {8'hCC, 2'd0, 2'd2, 2'd0},   // R1 R4 copy, 32 bpp
        {8'hF0, 2'd0, 2'd0, 2'd0},   // R2 pattern, 8 bpp
        {8'h66, 2'd0, 2'd1, 2'd0},   // R1 S xor D, 16 bpp
        {8'hCC, 2'd1, 2'd2, 2'd0},   // R4 mono expand
        {8'h5A, 2'd2, 2'd1, 2'd0},   // R4 solid, P xor D
        {8'hCC, 2'd0, 2'd2, 2'd1},   // R5 source key
        {8'hF0, 2'd2, 2'd0, 2'd2},   // R5 destination key
        {8'hB8, 2'd0, 2'd2, 2'd0},   // R1 mixed
        {8'h00, 2'd1, 2'd0, 2'd3},   // R1 zero, mode 3 opaque
        {8'hFF, 2'd0, 2'd1, 2'd0}    // R3 ones masked to 16 bits
    };

    function automatic logic [DW-1:0] initv(int i);
        logic [7:0] a = 8'(i);
        return {a ^ 8'h5A, ~a, a * 8'd3, a + 8'd7};
    endfunction

    function automatic logic [DW-1:0] dmask(logic [1:0] d);
        return (d == 2'd0) ? 32'h0000_00FF : (d == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [DW-1:0] ref_pix(int x, int y);
        logic [DW-1:0] m = dmask(depth);
        logic [DW-1:0] s, p, d, r, old;
        logic [DW-1:0] w;
        bit wr;
        old = snap[(int'(dst_addr) + y * int'(dst_pitch) + x) % MW];
        d = old & m;
        p = (pattern[(y % 8) * 8 + (x % 8)] ? fg_color : bg_color) & m;
        if (src_mode == 2'd0)
            s = snap[(int'(src_addr) + y * int'(src_pitch) + x) % MW] & m;
        else if (src_mode == 2'd1) begin
            w = snap[(int'(src_addr) + y * int'(src_pitch) + x / 32) % MW];
            s = (w[x % 32] ? fg_color : bg_color) & m;
        end else
            s = fg_color & m;
        for (int b = 0; b < DW; b++) r[b] = rop[{p[b], s[b], d[b]}];
        r = r & m;
        case (trans_mode)
            2'd1:    wr = (s != (key_color & m));
            2'd2:    wr = (d == (key_color & m));
            default: wr = 1'b1;
        endcase
        return wr ? r : old;
    endfunction

    task automatic mem_init();
        for (int i = 0; i < MW; i++) begin
            mem[i]  = initv(i);
            snap[i] = initv(i);
        end
    endtask

    task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R6: whole memory must match the reference for the current command
    task automatic check_mem(string req);
        int bad = -1;
        for (int i = 0; i < MW; i++) expm[i] = snap[i];
        for (int y = 0; y < int'(height); y++)
            for (int x = 0; x < int'(width); x++)
                expm[(int'(dst_addr) + y * int'(dst_pitch) + x) % MW] = ref_pix(x, y);
        for (int i = 0; i < MW; i++)
            if (bad < 0 && mem[i] !== expm[i]) bad = i;
        if (bad < 0) check(1'b1, req, 0, 0);
        else check(1'b0, req, mem[bad], expm[bad]);
    endtask

    task automatic run_blit();
        int n = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 20000) check(1'b0, "R7 watchdog", 0, 1);
        @(negedge clk);
    endtask

    task automatic set_copy(int s, int d, int sp, int dp, int w, int h);
        src_addr = AW'(s); dst_addr = AW'(d);
        src_pitch = AW'(sp); dst_pitch = AW'(dp);
        width = CW'(w); height = CW'(h);
        rop = 8'hCC; src_mode = 2'd0; depth = 2'd2; trans_mode = 2'd0;
    endtask

    initial begin
        #(8 * 150000);
        n_tests++; n_fail++;
        $display("FAIL R7 global watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        pattern = 64'hA55A_3CC3_0FF0_1234;
        fg_color = 32'hCAFE_F00D; bg_color = 32'h1357_9BDF; key_color = '0;
        set_copy(400, 100, 16, 12, 10, 10);
        mem_init();
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_req, "R7 reset idle", {busy, done, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (VEC[k]) begin
            {rop, src_mode, depth, trans_mode} = VEC[k];
            set_copy(400, 100, 16, 12, 10, 10);
            {rop, src_mode, depth, trans_mode} = VEC[k];
            mem_init();
            if (trans_mode == 2'd1) key_color = initv(400 + 16 + 1);
            else if (trans_mode == 2'd2) key_color = initv(100 + 36 + 2);
            else key_color = '0;
            run_blit();
            check_mem($sformatf("R1 R2 R3 R4 R5 vector %0d", k));
        end
        trans_mode = 2'd0;

        // R8: empty rectangles
        for (int z = 0; z < 2; z++) begin
            set_copy(400, 100, 16, 12, (z == 0) ? 0 : 5, (z == 0) ? 5 : 0);
            mem_init();
            req_cnt = 0; done_cnt = 0;
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
            @(negedge clk);
            check(done === 1'b1, "R8 done two cycles after start", done, 1);
            @(negedge clk);
            check(req_cnt == 0 && done_cnt == 1, "R8 no access", req_cnt, 0);
            check_mem("R8 memory untouched");
        end

        // R6: overlapping copies
        set_copy(300, 301, 16, 16, 5, 3); mem_init(); run_blit(); check_mem("R6 shift right");
        set_copy(500, 516, 16, 16, 4, 3); mem_init(); run_blit(); check_mem("R6 shift down");
        set_copy(600, 599, 16, 16, 5, 3); mem_init(); run_blit(); check_mem("R6 shift left");

        // R7: start while busy is ignored
        set_copy(400, 100, 16, 12, 4, 4); mem_init();
        done_cnt = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (5) @(negedge clk);
        check(busy === 1'b1, "R7 busy during transfer", busy, 1);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (120) @(negedge clk);
        check(done_cnt == 1 && !busy, "R7 single done", done_cnt, 1);
        check_mem("R7 result after ignored start");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule